// File: doc/BRIEF.md
# Next-PC and Branch Unit

This unit picks the address of the following instruction for a 32-bit load-store processor. Each cycle that `step` is high, it reads the current program counter, the instruction word, an operand-equality flag and one source register value. At the next clock edge it registers the chosen successor address. The candidates are the sequential address, a PC-relative branch target, an absolute jump target and a register-held address.

The unit also produces the link write for procedure calls. When a jump-and-link is stepped, it raises a one-cycle write strobe and presents the return address together with the fixed link register index. It does not fetch instructions, read the register file or compare operands. The equality flag and the register value arrive already resolved from outside.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `next_pc` becomes RESET_PC (default 0), `link_we` becomes 0 and `link_data` becomes 0.
- R2: A stepped instruction whose opcode (bits 31:26) is not one of the control opcodes in R3, R4, R6, R7 or R8 sets `next_pc` to `pc`+4 one edge later. This includes an opcode of 0x08.
- R3: Opcode 0x04 (branch if equal) sets `next_pc` to `pc`+4 plus the sign-extended bits 15:0 shifted left by two when `regs_equal` is 1. When `regs_equal` is 0 it sets `next_pc` to `pc`+4.
- R4: Opcode 0x05 (branch if not equal) takes the same target as R3 when `regs_equal` is 0. When `regs_equal` is 1 it sets `next_pc` to `pc`+4.
- R5: The branch offset is relative to `pc`+4, not to `pc`, and it is signed. An offset field of 0x8000 moves back 0x20000 bytes from `pc`+4, and 0xFFFF moves back 4 bytes from `pc`+4.
- R6: Opcode 0x02 (jump) sets `next_pc` to bits 31:28 of `pc`+4, then instruction bits 25:0, then two zero bits, whatever `regs_equal` is.
- R7: Opcode 0x03 (jump and link) uses the R6 target. One edge later it raises `link_we` for exactly that one cycle, with `link_data` = `pc`+4 and `link_idx` = 31.
- R8: Opcode 0x00 with function field (bits 5:0) 0x08 sets `next_pc` to `rs_value`. Opcode 0x00 with any other function field follows R2.
- R9: An edge with `step` low leaves `next_pc` unchanged and `link_we` low, whatever the other inputs are.
- R10: `link_we` is never raised for branches, plain jumps or register jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | The instruction on `instr` is to be resolved this cycle |
| pc | input | 32 | Address of the instruction being resolved |
| instr | input | 32 | Instruction word |
| regs_equal | input | 1 | 1 when the two compared register operands are equal |
| rs_value | input | 32 | Value of the source register for register jumps |
| next_pc | output | 32 | Registered successor address |
| link_we | output | 1 | One-cycle strobe to write the return address |
| link_idx | output | 5 | Register index written on a link (31) |
| link_data | output | 32 | Return address for the link write |

## Verification
The assertions assume that `regs_equal` and `rs_value` are valid and settled in every cycle where `step` is high, and that `pc` is word aligned. The properties on the return address and on the sequential fall-through depend on that. The stimulus drives all inputs at the falling edge and changes them only there. It only uses aligned addresses, and it gives the flag both values under each branch polarity. Idle cycles carry control opcodes on purpose so that the hold behaviour is exercised. Reset is applied only at the start.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN   = 32;
    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int IMM_W  = 16;
    localparam int IDX_W  = 26;
    localparam int REG_W  = 5;
    localparam int HI_W   = XLEN - IDX_W - 2;

    localparam logic [OP_W-1:0]  OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0]  OPC_JUMP  = 6'h02;
    localparam logic [OP_W-1:0]  OPC_JLINK = 6'h03;
    localparam logic [OP_W-1:0]  OPC_BREQ  = 6'h04;
    localparam logic [OP_W-1:0]  OPC_BRNE  = 6'h05;
    localparam logic [FN_W-1:0]  FN_JREG   = 6'h08;
    localparam logic [REG_W-1:0] LINK_REG  = 5'd31;
    localparam logic [XLEN-1:0]  STEP_SIZE = 32'd4;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BR_EQ,
        FLOW_BR_NE,
        FLOW_JUMP,
        FLOW_JLINK,
        FLOW_JREG
    } flow_e;

    typedef struct packed {
        flow_e             kind;
        logic [IMM_W-1:0]  offset;
        logic [IDX_W-1:0]  index;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] jump;
    } tgt_t;

    function automatic flow_e classify(input logic [OP_W-1:0] op,
                                       input logic [FN_W-1:0] fn);
        flow_e k;
        unique case (op)
            OPC_BREQ:  k = FLOW_BR_EQ;
            OPC_BRNE:  k = FLOW_BR_NE;
            OPC_JUMP:  k = FLOW_JUMP;
            OPC_JLINK: k = FLOW_JLINK;
            OPC_RTYPE: k = (fn == FN_JREG) ? FLOW_JREG : FLOW_SEQ;
            default:   k = FLOW_SEQ;
        endcase
        return k;
    endfunction

    function automatic logic [XLEN-1:0] scaled_offset(input logic [IMM_W-1:0] imm);
        logic [XLEN-1:0] wide;
        wide = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        return wide << 2;
    endfunction
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    logic [OP_W-1:0] op_f;
    logic [FN_W-1:0] fn_f;

    assign op_f = instr[XLEN-1 -: OP_W];
    assign fn_f = instr[FN_W-1:0];

    always_comb begin
        dec.kind   = classify(op_f, fn_f);
        dec.offset = instr[IMM_W-1:0];
        dec.index  = instr[IDX_W-1:0];
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc,
    input  dec_t            dec,
    output tgt_t            tgt
);
    logic [XLEN-1:0] after_pc;

    assign after_pc = pc + STEP_SIZE;

    always_comb begin
        tgt.seq    = after_pc;
        tgt.branch = after_pc + scaled_offset(dec.offset);
        tgt.jump   = {after_pc[XLEN-1 -: HI_W], dec.index, 2'b00};
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [XLEN-1:0]  pc,
    input  dec_t             dec,
    input  tgt_t             tgt,
    input  logic             regs_equal,
    input  logic [XLEN-1:0]  rs_value,
    output logic [XLEN-1:0]  next_pc,
    output logic             link_we,
    output logic [XLEN-1:0]  link_data
);
    logic [XLEN-1:0] chosen;
    logic            is_call;
    logic            started;

    always_comb begin
        unique case (dec.kind)
            FLOW_BR_EQ: chosen = regs_equal  ? tgt.branch : tgt.seq;
            FLOW_BR_NE: chosen = !regs_equal ? tgt.branch : tgt.seq;
            FLOW_JUMP,
            FLOW_JLINK: chosen = tgt.jump;
            FLOW_JREG:  chosen = rs_value;
            default:    chosen = tgt.seq;
        endcase
    end

    assign is_call = step && (dec.kind == FLOW_JLINK);

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc   <= RESET_PC;
            link_we   <= 1'b0;
            link_data <= '0;
            started   <= 1'b0;
        end else begin
            started <= 1'b1;
            link_we <= is_call;
            if (step)
                next_pc <= chosen;
            if (is_call)
                link_data <= tgt.seq;
        end
    end

    AST_LINK_SOURCE: assert property (@(posedge clk) disable iff (rst || !started)
        link_we |-> ($past(step) && $past(dec.kind) == FLOW_JLINK)); // R10
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst || !started)
        link_we |-> (link_data == $past(pc) + STEP_SIZE)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !started)
        !$past(step) |-> ($stable(next_pc) && !link_we)); // R9
    AST_JREG_LOAD: assert property (@(posedge clk) disable iff (rst || !started)
        ($past(step) && $past(dec.kind) == FLOW_JREG) |-> (next_pc == $past(rs_value))); // R8
    AST_EQ_FALLTHRU: assert property (@(posedge clk) disable iff (rst || !started)
        ($past(step) && $past(dec.kind) == FLOW_BR_EQ && !$past(regs_equal))
            |-> (next_pc == $past(pc) + STEP_SIZE)); // R3
    AST_NE_FALLTHRU: assert property (@(posedge clk) disable iff (rst || !started)
        ($past(step) && $past(dec.kind) == FLOW_BR_NE && $past(regs_equal))
            |-> (next_pc == $past(pc) + STEP_SIZE)); // R4
    AST_JUMP_ALIGN: assert property (@(posedge clk) disable iff (rst || !started)
        ($past(step) && $past(dec.kind) == FLOW_JUMP) |-> (next_pc[1:0] == 2'b00)); // R6
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic [31:0] pc,
    input  logic [31:0] instr,
    input  logic        regs_equal,
    input  logic [31:0] rs_value,
    output logic [31:0] next_pc,
    output logic        link_we,
    output logic [4:0]  link_idx,
    output logic [31:0] link_data
);
    dec_t dec;
    tgt_t tgt;

    npc_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    npc_target u_target (
        .pc  (pc),
        .dec (dec),
        .tgt (tgt)
    );

    npc_select #(.RESET_PC(RESET_PC)) u_select (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .pc         (pc),
        .dec        (dec),
        .tgt        (tgt),
        .regs_equal (regs_equal),
        .rs_value   (rs_value),
        .next_pc    (next_pc),
        .link_we    (link_we),
        .link_data  (link_data)
    );

    assign link_idx = LINK_REG;

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (next_pc == RESET_PC && !link_we)); // R1
endmodule

// File: tb/npc_unit_bench.sv
`timescale 1ns/1ps
module npc_unit_bench;
    localparam real HALF = 4.0;

    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [31:0] pc;
    logic [31:0] instr;
    logic        regs_equal;
    logic [31:0] rs_value;
    logic [31:0] next_pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    always #(HALF) clk = ~clk;

    npc_unit u_npc_unit (
        .clk(clk), .rst(rst), .step(step), .pc(pc), .instr(instr),
        .regs_equal(regs_equal), .rs_value(rs_value),
        .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data)
    );

    typedef struct {
        logic [31:0] npc;
        logic        we;
        logic [31:0] ldata;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] model_pc = 32'h0;
    bit          done     = 0;

    function automatic logic [31:0] i_br(input logic [5:0] op, input logic [15:0] off);
        return {op, 5'd1, 5'd2, off};
    endfunction
    function automatic logic [31:0] i_jmp(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction
    function automatic logic [31:0] i_r(input logic [5:0] fn);
        return {6'h00, 5'd31, 5'd0, 5'd0, 5'd0, fn};
    endfunction

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input bit s, input logic [31:0] p, input logic [31:0] ins,
                         input bit eq, input logic [31:0] rv, input string tag);
        exp_t e;
        logic [31:0] p4;
        logic [5:0]  op;
        bit          call;
        @(negedge clk);
        step = s; pc = p; instr = ins; regs_equal = eq; rs_value = rv;
        p4   = p + 32'd4;
        op   = ins[31:26];
        call = 0;
        if (s) begin
            case (op)
                6'h04: model_pc = eq  ? p4 + ({{16{ins[15]}}, ins[15:0]} << 2) : p4;
                6'h05: model_pc = !eq ? p4 + ({{16{ins[15]}}, ins[15:0]} << 2) : p4;
                6'h02: model_pc = {p4[31:28], ins[25:0], 2'b00};
                6'h03: begin model_pc = {p4[31:28], ins[25:0], 2'b00}; call = 1; end
                6'h00: model_pc = (ins[5:0] == 6'h08) ? rv : p4;
                default: model_pc = p4;
            endcase
        end
        e.npc = model_pc; e.we = call; e.ldata = p4; e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check32(e.tag, "next_pc", next_pc, e.npc);
                check32(e.tag, "link_we", {31'd0, link_we}, {31'd0, e.we});
                if (e.we) begin
                    check32(e.tag, "link_data", link_data, e.ldata);
                    check32(e.tag, "link_idx", {27'd0, link_idx}, 32'd31);
                end
            end
        end
    end

    initial begin : watchdog
        #(HALF * 2 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        rst = 1; step = 0; pc = '0; instr = '0; regs_equal = 0; rs_value = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check32("R1", "next_pc", next_pc, 32'h0);
        check32("R1", "link_we", {31'd0, link_we}, 32'd0);
        check32("R1", "link_data", link_data, 32'd0);
        rst = 0;
        // R2 sequential flow, ordinary opcode and wrap at top of space
        drive(1, 32'h0000_1000, 32'h2001_0005, 0, 32'h0, "R2");
        drive(1, 32'hFFFF_FFFC, 32'h8C22_0000, 1, 32'h0, "R2");
        // R3 equal branch, taken and not taken
        drive(1, 32'h0000_2000, i_br(6'h04, 16'h0010), 1, 32'h0, "R3");
        drive(1, 32'h0000_2000, i_br(6'h04, 16'h0010), 0, 32'h0, "R3");
        // R4 not-equal branch, taken and not taken
        drive(1, 32'h0000_3000, i_br(6'h05, 16'h0003), 0, 32'h0, "R4");
        drive(1, 32'h0000_3000, i_br(6'h05, 16'h0003), 1, 32'h0, "R4");
        // R5 signed offsets relative to pc+4
        drive(1, 32'h0004_0000, i_br(6'h04, 16'h8000), 1, 32'h0, "R5");
        drive(1, 32'h0000_0100, i_br(6'h05, 16'hFFFF), 0, 32'h0, "R5");
        drive(1, 32'h0000_0100, i_br(6'h04, 16'h0000), 1, 32'h0, "R5");
        // R6 jump, upper bits from pc+4 including carry into bit 28
        drive(1, 32'hA000_0010, i_jmp(6'h02, 26'h123_4567), 0, 32'h0, "R6");
        drive(1, 32'h0FFF_FFFC, i_jmp(6'h02, 26'h3FF_FFFF), 1, 32'h0, "R6");
        // R7 jump and link, pulse ends after one cycle, back-to-back calls
        drive(1, 32'h4000_0200, i_jmp(6'h03, 26'h000_0040), 0, 32'h0, "R7");
        drive(0, 32'h0, 32'h0, 0, 32'h0, "R7");
        drive(1, 32'h5000_0000, i_jmp(6'h03, 26'h000_0001), 0, 32'h0, "R7");
        drive(1, 32'h6000_0004, i_jmp(6'h03, 26'h000_0002), 1, 32'h0, "R7");
        // R8 register jump and other R-type function codes
        drive(1, 32'h0000_4000, i_r(6'h08), 0, 32'hDEAD_BEE0, "R8");
        drive(1, 32'h0000_4000, i_r(6'h20), 0, 32'hDEAD_BEE0, "R8");
        drive(1, 32'h0000_4000, i_r(6'h09), 1, 32'h1234_5678, "R8");
        // R9 idle cycles with control instructions presented
        drive(0, 32'h0000_9000, i_jmp(6'h03, 26'h000_0777), 0, 32'h0, "R9");
        drive(0, 32'h0000_9000, i_r(6'h08), 1, 32'hCAFE_0000, "R9");
        drive(0, 32'h0000_9000, i_br(6'h04, 16'h0040), 1, 32'h0, "R9");
        // R10 no link strobe on the other control flows
        drive(1, 32'h0000_5000, i_br(6'h04, 16'h0001), 1, 32'h0, "R10");
        drive(1, 32'h0000_5000, i_jmp(6'h02, 26'h000_0100), 0, 32'h0, "R10");
        drive(1, 32'h0000_5000, i_r(6'h08), 0, 32'h0000_7000, "R10");
        @(negedge clk);
        step = 0;
        repeat (4) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule